// File: doc/BRIEF.md
# Preloadable Periodic Tick Timer

This block is a 16-bit periodic timer that counts up. A prescaler outside the block supplies a one-cycle strobe at the tick rate, nominally 160 kHz. The counter takes a step on each strobe while it is enabled. When it steps past 0xFFFF it does not return to zero. It loads a programmable preload value instead, so the period in ticks is 0x10000 minus the preload.

Each wrap adds one to a small overflow tally and marks an interrupt pending. The tally stops at its maximum value rather than rolling over. Software rebuilds elapsed time from the live count and the tally. It reads the count, then the tally, and reads the count again if the tally moved. For that reason the count register always returns the live value.

The interrupt request carries a programmable 3-bit priority level. All state sits behind a small 16-bit register port with two byte lanes. Address 0 is the preload, 1 the count, 2 the control byte and 3 the interrupt-control byte. Byte-wide registers occupy the low lane, and their upper lane reads zero.

Top module: `ptick_timer`

## Requirements
- R1: After reset, reads at all four addresses return 0, `irq_req` is 0 and `irq_level` is 0.
- R2: The count increases by exactly one on a clock in which `tick_stb` is 1 and both control bit 0 (counter enable) and control bit 1 (tick enable) are 1. Otherwise it holds.
- R3: An advance from 0xFFFF loads the preload value into the count, so the steady period is 0x10000 minus the preload ticks.
- R4: Each wrap adds one to the overflow tally, which reads back in control bits [7:4].
- R5: The tally saturates at 15 and stays there on further wraps.
- R6: Writing the control register with bit 2 set clears the tally and still updates bits 1:0. Bits 3 and 2 always read 0.
- R7: A wrap sets the pending flag, read as interrupt-control bit 7. Writing interrupt control with bit 7 set clears it.
- R8: One clock after pending and enable (interrupt-control bit 3) are both 1, `irq_req` is 1 and `irq_level` equals interrupt-control bits [2:0]. Otherwise both outputs are 0.
- R9: Writing the preload leaves the running count unchanged until the next reload. The count address is read-only, and a read returns the live count.
- R10: A preload write updates only the byte lanes whose `bus_be` bit is set (bit 0 selects [7:0], bit 1 selects [15:8]).
- R11: Read data appears on `bus_rdata` on the clock after the one with `bus_rd` high, and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_stb | input | 1 | One-cycle tick strobe from the external prescaler |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address: 0 preload, 1 count, 2 control, 3 interrupt control |
| bus_be | input | 2 | Byte-lane enables for writes |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| irq_req | output | 1 | Interrupt request |
| irq_level | output | 3 | Priority level of the active request, zero when idle |

## Verification
The assertions assume that reset is held for at least one clock. They also assume that `tick_stb` and the bus strobes are clean single-clock levels sampled on the rising edge. The bench drives every input on the falling edge and holds the strobe for whole clocks only. It reaches the first wrap by running the strobe continuously from a known count. It then uses preload values near 0xFFFF, which gives short periods for the reload, saturation and interrupt cases.

// File: rtl/ptick_pkg.sv
package ptick_pkg;
  typedef enum logic [1:0] {
    REG_PRELOAD = 2'd0,
    REG_COUNT   = 2'd1,
    REG_CTRL    = 2'd2,
    REG_ICTL    = 2'd3
  } ptick_reg_e;

  localparam int CTRL_RUN_BIT   = 0;
  localparam int CTRL_TICK_BIT  = 1;
  localparam int CTRL_CLR_BIT   = 2;
  localparam int CTRL_TALLY_LSB = 4;
  localparam int ICTL_EN_BIT    = 3;
  localparam int ICTL_PEND_BIT  = 7;
endpackage

// File: rtl/ptick_counter.sv
module ptick_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic [CNT_W-1:0] preload,
  output logic [CNT_W-1:0] count,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

  // a step taken at the top value is a wrap
  assign wrap = step && (count == CNT_TOP);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (step) begin
      if (count == CNT_TOP) count <= preload;
      else                  count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/ptick_tally.sv
module ptick_tally #(
  parameter int TALLY_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               inc,
  input  logic               clr,
  output logic [TALLY_W-1:0] tally
);
  localparam logic [TALLY_W-1:0] TALLY_MAX = {TALLY_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      tally <= '0;
    end else if (inc && (tally != TALLY_MAX)) begin
      tally <= tally + 1'b1;
    end
  end
endmodule

// File: rtl/ptick_irq.sv
module ptick_irq #(
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_pend,
  input  logic             clr_pend,
  input  logic             irq_en,
  input  logic [LVL_W-1:0] lvl,
  output logic             pending,
  output logic             irq_req,
  output logic [LVL_W-1:0] irq_level
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
    end else if (set_pend) begin
      pending <= 1'b1;
    end else if (clr_pend) begin
      pending <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req   <= 1'b0;
      irq_level <= '0;
    end else begin
      irq_req   <= pending && irq_en;
      irq_level <= (pending && irq_en) ? lvl : '0;
    end
  end
endmodule

// File: rtl/ptick_regs.sv
module ptick_regs
  import ptick_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int TALLY_W = 4,
  parameter int LVL_W   = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [1:0]         bus_addr,
  input  logic [1:0]         bus_be,
  input  logic [CNT_W-1:0]   bus_wdata,
  input  logic [CNT_W-1:0]   count,
  input  logic [TALLY_W-1:0] tally,
  input  logic               pending,
  output logic [CNT_W-1:0]   preload,
  output logic               run_en,
  output logic               tick_en,
  output logic               clr_tally,
  output logic               irq_en,
  output logic [LVL_W-1:0]   irq_lvl,
  output logic               clr_pend,
  output logic [CNT_W-1:0]   bus_rdata
);
  localparam int LANES = CNT_W / 8;

  logic wr_pre, wr_ctrl, wr_ictl;
  logic [7:0] ctrl_view, ictl_view;

  assign wr_pre  = bus_wr && (bus_addr == REG_PRELOAD);
  assign wr_ctrl = bus_wr && (bus_addr == REG_CTRL)  && bus_be[0];
  assign wr_ictl = bus_wr && (bus_addr == REG_ICTL)  && bus_be[0];

  assign clr_tally = wr_ctrl && bus_wdata[CTRL_CLR_BIT];
  assign clr_pend  = wr_ictl && bus_wdata[ICTL_PEND_BIT];

  // preload register, one writable byte per lane
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        preload[g*8 +: 8] <= '0;
      end else if (wr_pre && bus_be[g]) begin
        preload[g*8 +: 8] <= bus_wdata[g*8 +: 8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_en  <= 1'b0;
      tick_en <= 1'b0;
    end else if (wr_ctrl) begin
      run_en  <= bus_wdata[CTRL_RUN_BIT];
      tick_en <= bus_wdata[CTRL_TICK_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_en  <= 1'b0;
      irq_lvl <= '0;
    end else if (wr_ictl) begin
      irq_en  <= bus_wdata[ICTL_EN_BIT];
      irq_lvl <= bus_wdata[LVL_W-1:0];
    end
  end

  always_comb begin
    ctrl_view = '0;
    ctrl_view[CTRL_RUN_BIT]  = run_en;
    ctrl_view[CTRL_TICK_BIT] = tick_en;
    ctrl_view[CTRL_TALLY_LSB +: TALLY_W] = tally;
    ictl_view = '0;
    ictl_view[LVL_W-1:0]    = irq_lvl;
    ictl_view[ICTL_EN_BIT]  = irq_en;
    ictl_view[ICTL_PEND_BIT] = pending;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        REG_PRELOAD: bus_rdata <= preload;
        REG_COUNT:   bus_rdata <= count;
        REG_CTRL:    bus_rdata <= {{(CNT_W-8){1'b0}}, ctrl_view};
        default:     bus_rdata <= {{(CNT_W-8){1'b0}}, ictl_view};
      endcase
    end
  end
endmodule

// File: rtl/ptick_timer.sv
module ptick_timer #(
  parameter int CNT_W   = 16,
  parameter int TALLY_W = 4,
  parameter int LVL_W   = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_stb,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [1:0]       bus_addr,
  input  logic [1:0]       bus_be,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  output logic             irq_req,
  output logic [LVL_W-1:0] irq_level
);
  logic [CNT_W-1:0]   cnt_val;
  logic [CNT_W-1:0]   pre_val;
  logic [TALLY_W-1:0] tally_val;
  logic               run_en, tick_en, clr_tally;
  logic               irq_en, clr_pend, pend_val;
  logic [LVL_W-1:0]   irq_lvl;
  logic               step, wrap_evt;

  assign step = tick_stb && run_en && tick_en;

  ptick_regs #(.CNT_W(CNT_W), .TALLY_W(TALLY_W), .LVL_W(LVL_W)) u_regs (
    .clk(clk), .rst(rst),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata),
    .count(cnt_val), .tally(tally_val), .pending(pend_val),
    .preload(pre_val), .run_en(run_en), .tick_en(tick_en),
    .clr_tally(clr_tally), .irq_en(irq_en), .irq_lvl(irq_lvl),
    .clr_pend(clr_pend), .bus_rdata(bus_rdata)
  );

  ptick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .step(step), .preload(pre_val),
    .count(cnt_val), .wrap(wrap_evt)
  );

  ptick_tally #(.TALLY_W(TALLY_W)) u_tally (
    .clk(clk), .rst(rst), .inc(wrap_evt), .clr(clr_tally), .tally(tally_val)
  );

  ptick_irq #(.LVL_W(LVL_W)) u_irq (
    .clk(clk), .rst(rst), .set_pend(wrap_evt), .clr_pend(clr_pend),
    .irq_en(irq_en), .lvl(irq_lvl), .pending(pend_val),
    .irq_req(irq_req), .irq_level(irq_level)
  );
endmodule

// File: rtl/ptick_checker.sv
module ptick_checker #(
  parameter int CNT_W   = 16,
  parameter int TALLY_W = 4,
  parameter int LVL_W   = 3
) (
  input logic               clk,
  input logic               rst,
  input logic               step,
  input logic [CNT_W-1:0]   cnt,
  input logic [CNT_W-1:0]   pre,
  input logic               wrap,
  input logic [TALLY_W-1:0] tally,
  input logic               clr_tally,
  input logic               pending,
  input logic               irq_req,
  input logic [LVL_W-1:0]   irq_level
);
  localparam logic [TALLY_W-1:0] TMAX = {TALLY_W{1'b1}};

  a_r2_hold_without_step: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(cnt));

  a_r2_step_by_one: assert property (@(posedge clk) disable iff (rst)
    (step && !wrap) |=> (cnt == $past(cnt) + 1'b1));

  a_r3_reload_on_wrap: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (cnt == $past(pre)));

  a_r5_tally_saturates: assert property (@(posedge clk) disable iff (rst)
    (tally == TMAX && !clr_tally) |=> (tally == TMAX));

  a_r7_wrap_sets_pending: assert property (@(posedge clk) disable iff (rst)
    wrap |=> pending);

  a_r8_idle_level_zero: assert property (@(posedge clk) disable iff (rst)
    !irq_req |-> (irq_level == '0));

  a_r8_req_needs_pending: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_req) |-> $past(pending));
endmodule

bind ptick_timer ptick_checker #(.CNT_W(CNT_W), .TALLY_W(TALLY_W), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst(rst), .step(step), .cnt(cnt_val), .pre(pre_val),
  .wrap(wrap_evt), .tally(tally_val), .clr_tally(clr_tally),
  .pending(pend_val), .irq_req(irq_req), .irq_level(irq_level)
);

// File: tb/test_ptick_timer.sv
`timescale 1ns/1ps
module test_ptick_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_stb = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [1:0]  bus_be = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq_req;
  logic [2:0]  irq_level;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ptick_timer i_ptick_timer (
    .clk(clk), .rst(rst), .tick_stb(tick_stb), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_req(irq_req), .irq_level(irq_level)
  );

  task automatic check(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d, input logic [1:0] be = 2'b11);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic run_ticks(input int n);
    @(negedge clk);
    tick_stb = 1'b1;
    repeat (n) @(negedge clk);
    tick_stb = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], d);
      check("R1", "reset register read", d, 16'h0000);
    end
    check("R1", "reset irq_req", {15'd0, irq_req}, 16'd0);
    check("R1", "reset irq_level", {13'd0, irq_level}, 16'd0);
  endtask

  task automatic t_enables();
    logic [15:0] d;
    wr(2, 16'h0003);
    run_ticks(3);
    rd(1, d); check("R2", "count after 3 ticks", d, 16'd3);
    run_ticks(1); repeat (3) @(negedge clk);
    run_ticks(1); repeat (3) @(negedge clk);
    rd(1, d); check("R2", "count after isolated pulses", d, 16'd5);
    check("R11", "read data holds", bus_rdata, 16'd5);
    wr(2, 16'h0002);
    run_ticks(4);
    rd(1, d); check("R2", "counter enable off", d, 16'd5);
    wr(2, 16'h0001);
    run_ticks(4);
    rd(1, d); check("R2", "tick enable off", d, 16'd5);
    wr(2, 16'h0003);
    repeat (5) @(negedge clk);
    rd(1, d); check("R2", "no strobe no step", d, 16'd5);
  endtask

  task automatic t_reload();
    logic [15:0] d;
    wr(0, 16'hFFF0);
    rd(1, d); check("R9", "preload write leaves count", d, 16'd5);
    rd(0, d); check("R9", "preload readback", d, 16'hFFF0);
    run_ticks(65530);
    rd(1, d); check("R3", "count at top", d, 16'hFFFF);
    rd(2, d); check("R4", "tally before wrap", d, 16'h0003);
    run_ticks(1);
    rd(1, d); check("R3", "reload value", d, 16'hFFF0);
    rd(2, d); check("R4", "tally after first wrap", d, 16'h0013);
    rd(3, d); check("R7", "pending after wrap", d, 16'h0080);
    check("R8", "no request while disabled", {15'd0, irq_req}, 16'd0);
    run_ticks(16);
    rd(1, d); check("R3", "one full period", d, 16'hFFF0);
    rd(2, d); check("R4", "tally after second wrap", d, 16'h0023);
    run_ticks(8);
    rd(1, d); check("R9", "live count mid period", d, 16'hFFF8);
  endtask

  task automatic t_saturate();
    logic [15:0] d;
    wr(0, 16'hFFFF);
    run_ticks(40);
    rd(2, d); check("R5", "tally saturated", d, 16'h00F3);
    rd(1, d); check("R3", "period of one tick", d, 16'hFFFF);
    wr(2, 16'h0007);
    rd(2, d); check("R6", "tally cleared, enables kept", d, 16'h0003);
  endtask

  task automatic t_bytes();
    logic [15:0] d;
    wr(0, 16'h1234, 2'b01);
    rd(0, d); check("R10", "low lane only", d, 16'hFF34);
    wr(0, 16'hAB00, 2'b10);
    rd(0, d); check("R10", "high lane only", d, 16'hAB34);
    wr(1, 16'h1111);
    rd(1, d); check("R9", "count write ignored", d, 16'hFFFF);
  endtask

  task automatic t_irq();
    logic [15:0] d;
    wr(3, 16'h000D);
    @(negedge clk);
    check("R8", "request raised", {15'd0, irq_req}, 16'd1);
    check("R8", "level driven", {13'd0, irq_level}, 16'd5);
    rd(3, d); check("R7", "ictl readback", d, 16'h008D);
    wr(3, 16'h008D);
    @(negedge clk);
    check("R8", "request dropped", {15'd0, irq_req}, 16'd0);
    check("R8", "level zero when idle", {13'd0, irq_level}, 16'd0);
    rd(3, d); check("R7", "pending cleared", d, 16'h000D);
    run_ticks(1);
    @(negedge clk);
    check("R8", "request on new wrap", {15'd0, irq_req}, 16'd1);
    rd(1, d); check("R3", "reload with byte-built preload", d, 16'hAB34);
    wr(3, 16'h0005);
    @(negedge clk);
    check("R8", "enable off drops request", {15'd0, irq_req}, 16'd0);
    rd(3, d); check("R7", "pending kept while disabled", d, 16'h0085);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_enables();
    t_reload();
    t_saturate();
    t_bytes();
    t_irq();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule